// File: doc/BRIEF.md
# Boundary-Scan Instruction Register with Decoder

This block holds the instruction path of a boundary-scan test port on a device that has no identification register. It contains an eight-bit instruction shift stage, a shadow stage that holds the active instruction, a single-bit bypass stage, and the final output stage that drives the serial test data out. An external TAP state machine drives it with one-hot state strobes, and the block acts on them on the test clock edges.

The active instruction is decoded into three controls for the boundary cells. The first makes the cells drive the pads. The second forces every pad to high impedance. The third picks the boundary register, rather than the bypass bit, as the data register between serial in and serial out. Four opcodes carry meaning, and every other opcode behaves as bypass. The value the instruction register loads on capture is fixed and differs from device to device. A board tester can read it back as a stand-in identity code.

Top module: `tap_instr_unit`

## Requirements
- R1: When `capture_ir` is high at a rising `tck`, the instruction shift stage loads 8'h3D. The first eight bits then shifted out on `tdo` are 1,0,1,1,1,1,0,0 in that order, starting with bit 0.
- R2: In Shift-IR, each rising `tck` moves the stage one place toward `tdo`, and `tdi` enters at bit 7. A bit shifted in appears on `tdo` eight shifts later.
- R3: The active instruction, and so all three decode outputs, changes only on a falling `tck` while `update_ir` is high. Shifting a new code without an update leaves the outputs as they were.
- R4: Opcode 8'h00 gives `test_mode`=1, `bsr_sel`=1 and `force_hiz`=0.
- R5: Opcode 8'h81 gives `bsr_sel`=1, `test_mode`=0 and `force_hiz`=0.
- R6: Opcode 8'h82 gives `test_mode`=1, `bsr_sel`=0 and `force_hiz`=0.
- R7: Opcode 8'h03 gives `force_hiz`=1, `test_mode`=0 and `bsr_sel`=0.
- R8: Every other opcode decodes as bypass, with all three decode outputs at 0.
- R9: When `capture_dr` is high at a rising `tck`, the bypass bit loads 0. In Shift-DR with `bsr_sel`=0, `tdo` first shows that 0 and then shows each `tdi` bit one shift later.
- R10: `tdo` and `tdo_en` change only on a falling `tck`. `tdo_en` is 1 exactly when `shift_ir` or `shift_dr` is high. In Shift-DR with `bsr_sel`=1, `tdo` takes the value of `bsr_tdo`.
- R11: While `rst_n` is low, the active instruction is bypass (all decode outputs 0) and `tdo_en` is 0. This takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous test-logic reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | TAP is in Capture-IR |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| bsr_tdo | input | 1 | Serial output of the boundary register chain |
| tdo | output | 1 | Serial test data out |
| tdo_en | output | 1 | Output enable for `tdo` |
| test_mode | output | 1 | Boundary cells drive the pads |
| force_hiz | output | 1 | All pads forced to high impedance |
| bsr_sel | output | 1 | Boundary register selected as data register |

## Verification
The decoder is tried with each of the four meaningful opcodes, with opcodes one bit away from them, and with random bytes. This separates an exact compare from a partial match, and it shows that the fallback covers everything not listed. Long instruction shifts of sixteen bits show the capture constant followed by the shifted-in bits. These separate shift direction and length from the capture value. Shifts that end without an update show that the active instruction is protected. Data-register scans are run with the bypass bit and with the boundary chain selected. They separate the captured zero and the one-cycle delay from a pass-through of `bsr_tdo`. A reset in the middle of a sequence shows the asynchronous return to bypass.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [2:0] {
    INS_EXTEST,
    INS_SAMPLE,
    INS_CLAMP,
    INS_HIGHZ,
    INS_BYPASS
  } ins_e;

  typedef struct packed {
    logic drive_pads;
    logic float_pads;
    logic route_bsr;
  } ctl_t;

  function automatic ctl_t ctl_of(ins_e ins);
    ctl_t c;
    c = '0;
    case (ins)
      INS_EXTEST: begin c.drive_pads = 1'b1; c.route_bsr = 1'b1; end
      INS_SAMPLE: c.route_bsr  = 1'b1;
      INS_CLAMP:  c.drive_pads = 1'b1;
      INS_HIGHZ:  c.float_pads = 1'b1;
      default:    c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tis_ir_chain.sv
module tis_ir_chain #(
  parameter int          W   = 8,
  parameter logic [W-1:0] CAP = 8'h3D,
  parameter logic [W-1:0] RST = 8'hFF
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         tdi,
  input  logic         cap,
  input  logic         shift,
  input  logic         update,
  output logic [W-1:0] sr,
  output logic [W-1:0] active
);

  function automatic logic [W-1:0] shift_in(logic [W-1:0] v, logic b);
    return {b, v[W-1:1]};
  endfunction

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr <= CAP;
    else if (cap)   sr <= CAP;
    else if (shift) sr <= shift_in(sr, tdi);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      active <= RST;
    else if (update) active <= sr;
  end

endmodule

// File: rtl/tis_decode.sv
module tis_decode
  import tis_pkg::*;
#(
  parameter int          W          = 8,
  parameter logic [W-1:0] OPC_EXTEST = 8'h00,
  parameter logic [W-1:0] OPC_SAMPLE = 8'h81,
  parameter logic [W-1:0] OPC_CLAMP  = 8'h82,
  parameter logic [W-1:0] OPC_HIGHZ  = 8'h03
) (
  input  logic [W-1:0] code,
  output ctl_t         ctl
);

  function automatic ins_e classify(logic [W-1:0] c);
    if      (c == OPC_EXTEST) return INS_EXTEST;
    else if (c == OPC_SAMPLE) return INS_SAMPLE;
    else if (c == OPC_CLAMP)  return INS_CLAMP;
    else if (c == OPC_HIGHZ)  return INS_HIGHZ;
    else                      return INS_BYPASS;
  endfunction

  ins_e ins;
  assign ins = classify(code);
  assign ctl = ctl_of(ins);

endmodule

// File: rtl/tis_bypass.sv
module tis_bypass (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic cap,
  input  logic shift,
  output logic bit_q
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (cap)   bit_q <= 1'b0;
    else if (shift) bit_q <= tdi;
  end

endmodule

// File: rtl/tis_tdo_stage.sv
module tis_tdo_stage (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_ir,
  input  logic shift_dr,
  input  logic ir_lsb,
  input  logic route_bsr,
  input  logic bsr_tdo,
  input  logic byp,
  output logic tdo,
  output logic tdo_en
);

  logic nxt;
  always_comb begin
    if (shift_ir)       nxt = ir_lsb;
    else if (route_bsr) nxt = bsr_tdo;
    else                nxt = byp;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= shift_ir | shift_dr;
      if (shift_ir | shift_dr) tdo <= nxt;
    end
  end

endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
  import tis_pkg::*;
#(
  parameter int              IR_W       = 8,
  parameter logic [IR_W-1:0] CAP_VAL    = 8'h3D,
  parameter logic [IR_W-1:0] OPC_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OPC_SAMPLE = 8'h81,
  parameter logic [IR_W-1:0] OPC_CLAMP  = 8'h82,
  parameter logic [IR_W-1:0] OPC_HIGHZ  = 8'h03
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tdi,
  input  logic capture_ir,
  input  logic shift_ir,
  input  logic update_ir,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_en,
  output logic test_mode,
  output logic force_hiz,
  output logic bsr_sel
);

  localparam logic [IR_W-1:0] RST_CODE = {IR_W{1'b1}};

  logic [IR_W-1:0] ir_sr_w;
  logic [IR_W-1:0] ir_act_w;
  logic            byp_w;
  ctl_t            ctl_w;

  tis_ir_chain #(.W(IR_W), .CAP(CAP_VAL), .RST(RST_CODE)) u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap(capture_ir),
    .shift(shift_ir), .update(update_ir), .sr(ir_sr_w), .active(ir_act_w)
  );

  tis_decode #(
    .W(IR_W), .OPC_EXTEST(OPC_EXTEST), .OPC_SAMPLE(OPC_SAMPLE),
    .OPC_CLAMP(OPC_CLAMP), .OPC_HIGHZ(OPC_HIGHZ)
  ) u_dec (
    .code(ir_act_w), .ctl(ctl_w)
  );

  tis_bypass u_byp (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .cap(capture_dr),
    .shift(shift_dr), .bit_q(byp_w)
  );

  tis_tdo_stage u_tdo (
    .tck(tck), .rst_n(rst_n), .shift_ir(shift_ir), .shift_dr(shift_dr),
    .ir_lsb(ir_sr_w[0]), .route_bsr(ctl_w.route_bsr), .bsr_tdo(bsr_tdo),
    .byp(byp_w), .tdo(tdo), .tdo_en(tdo_en)
  );

  assign test_mode = ctl_w.drive_pads;
  assign force_hiz = ctl_w.float_pads;
  assign bsr_sel   = ctl_w.route_bsr;

endmodule

// File: rtl/tis_sva.sv
module tis_sva #(
  parameter int              IR_W    = 8,
  parameter logic [IR_W-1:0] CAP_VAL = 8'h3D
) (
  input logic            tck,
  input logic            rst_n,
  input logic            capture_ir,
  input logic            shift_ir,
  input logic            update_ir,
  input logic            capture_dr,
  input logic            shift_dr,
  input logic            tdo_en,
  input logic            test_mode,
  input logic            force_hiz,
  input logic            bsr_sel,
  input logic [IR_W-1:0] ir_sr,
  input logic            byp
);

  // R1: the capture constant is present after a capture edge
  p_capture_val_r1: assert property (@(posedge tck) disable iff (!rst_n)
    capture_ir |=> (ir_sr == CAP_VAL));

  // R3: the decode outputs hold unless an update falling edge occurred
  p_hold_without_update_r3: assert property (@(negedge tck) disable iff (!rst_n)
    !update_ir |=> $stable({test_mode, force_hiz, bsr_sel}));

  // R7: high impedance excludes the other controls
  p_hiz_exclusive_r7: assert property (@(posedge tck) disable iff (!rst_n)
    force_hiz |-> (!test_mode && !bsr_sel));

  // R9: bypass captures zero
  p_bypass_zero_r9: assert property (@(posedge tck) disable iff (!rst_n)
    capture_dr |=> !byp);

  // R10: output enable tracks the shift states of the previous half cycle
  p_tdo_en_r10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_en == (shift_ir || shift_dr));

endmodule

bind tap_instr_unit tis_sva #(.IR_W(IR_W), .CAP_VAL(CAP_VAL)) u_sva (
  .tck(tck), .rst_n(rst_n), .capture_ir(capture_ir), .shift_ir(shift_ir),
  .update_ir(update_ir), .capture_dr(capture_dr), .shift_dr(shift_dr),
  .tdo_en(tdo_en), .test_mode(test_mode), .force_hiz(force_hiz),
  .bsr_sel(bsr_sel), .ir_sr(ir_sr_w), .byp(byp_w)
);

// File: tb/tb_tap_instr_unit.sv
module tb_tap_instr_unit;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, bsr_tdo = 1'b0;
  logic tdo, tdo_en, test_mode, force_hiz, bsr_sel;

  int checks = 0;
  int errors = 0;
  logic [7:0] cur_code = 8'hFF;

  always #2 tck = ~tck;

  tap_instr_unit dut (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .bsr_tdo(bsr_tdo), .tdo(tdo), .tdo_en(tdo_en),
    .test_mode(test_mode), .force_hiz(force_hiz), .bsr_sel(bsr_sel)
  );

  // Expected {test_mode, force_hiz, bsr_sel} for an opcode
  function automatic logic [2:0] exp_ctl(logic [7:0] c);
    case (c)
      8'h00:   return 3'b101;
      8'h81:   return 3'b001;
      8'h82:   return 3'b100;
      8'h03:   return 3'b010;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string req_of(logic [7:0] c);
    case (c)
      8'h00:   return "R4";
      8'h81:   return "R5";
      8'h82:   return "R6";
      8'h03:   return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Capture, shift n bits of data (LSB first), optional update
  task automatic ir_scan(logic [15:0] data, int n, bit upd);
    logic [23:0] expect_stream;
    expect_stream = {data, 8'h3D};
    capture_ir = 1'b1;
    @(posedge tck); #1;
    capture_ir = 1'b0;
    shift_ir   = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = data[i];
      @(negedge tck); #1;
      chk(i < 8 ? "R1" : "R2", tdo, expect_stream[i]);
      if (i == 0) chk("R10", tdo_en, 1'b1);
      @(posedge tck); #1;
    end
    shift_ir = 1'b0;
    if (upd) begin
      update_ir = 1'b1;
      cur_code  = (n >= 8) ? 8'(data >> (n - 8)) : cur_code;
    end
    @(negedge tck); #1;
    update_ir = 1'b0;
    chk("R10", tdo_en, 1'b0);
  endtask

  task automatic check_ctl(string req);
    chk(req, {test_mode, force_hiz, bsr_sel}, exp_ctl(cur_code));
  endtask

  task automatic dr_scan(int n);
    logic prev;
    logic b;
    capture_dr = 1'b1;
    @(posedge tck); #1;
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      tdi     = 1'($urandom);
      b       = 1'($urandom);
      bsr_tdo = b;
      @(negedge tck); #1;
      if (exp_ctl(cur_code) & 3'b001) chk("R10", tdo, b);
      else                            chk("R9", tdo, prev);
      prev = tdi;
      @(posedge tck); #1;
    end
    shift_dr = 1'b0;
    @(negedge tck); #1;
    chk("R10", tdo_en, 1'b0);
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] codes [8];
    logic [7:0] code;
    void'($urandom(32'h5eed_0042));
    codes = '{8'h00, 8'h81, 8'h82, 8'h03, 8'h01, 8'h80, 8'h83, 8'h02};

    // R11: reset state
    #7;
    chk("R11", {test_mode, force_hiz, bsr_sel}, 3'b000);
    chk("R11", tdo_en, 1'b0);
    @(posedge tck); #1;
    rst_n = 1'b1;
    @(posedge tck); #1;

    // Directed: each opcode and near-miss neighbours
    foreach (codes[k]) begin
      ir_scan({8'h00, codes[k]}, 8, 1'b1);
      check_ctl(req_of(codes[k]));
      dr_scan(6);
    end

    // R3: shift a new code but skip the update
    ir_scan(16'h0000, 8, 1'b1);
    check_ctl("R4");
    ir_scan(16'h0003, 8, 1'b0);
    check_ctl("R3");

    // R2: long shift, the last eight bits become the instruction
    ir_scan(16'h82A5, 16, 1'b1);
    check_ctl("R6");

    // R11: asynchronous reset while EXTEST is active
    ir_scan(16'h0000, 8, 1'b1);
    check_ctl("R4");
    #1 rst_n = 1'b0;
    #0.5;
    chk("R11", {test_mode, force_hiz, bsr_sel}, 3'b000);
    cur_code = 8'hFF;
    @(posedge tck); #1;
    rst_n = 1'b1;
    @(posedge tck); #1;
    dr_scan(4);

    // Random opcodes
    for (int r = 0; r < 40; r++) begin
      code = ($urandom % 3 == 0) ? codes[$urandom % 8] : 8'($urandom);
      ir_scan({8'($urandom), code}, 8, 1'b1);
      check_ctl(req_of(code));
      dr_scan(1 + ($urandom % 8));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule